// File: doc/BRIEF.md
# Dual-Port RAM with Contention Arbiter and Mailboxes

A synchronous two-port word memory. Both sides, left and right, each own an enable, a write strobe, four 9-bit byte-lane write enables, an address, write data and a registered read output. When both enabled ports point at the same word in the same cycle, an arbiter picks one winner. The other port sees a busy flag, and any write it presents is dropped. Reads still complete on both sides, and they return the word as it stands after the cycle's accepted writes.

The two highest words serve as mailboxes for passing messages between the ports. A write into the opposite side's mailbox raises that side's interrupt. The owner reading its own mailbox lowers the interrupt. A select input chooses master or slave operation. A master drives its arbitration result on the busy outputs. A slave keeps those outputs low and takes busy from a master device through its busy inputs. This lets several devices be ganged side by side for a wider word.

Top module: `dual_port_mailbox_ram`

## Requirements
- R1: In master mode (master_sel=1) a busy output is high only while both ports are enabled with equal addresses, and in that case exactly one of the two busy outputs is high, in the same cycle.
- R2: A port whose enable and address were both unchanged from the previous cycle, while the other port has just arrived, wins the new contention. Ownership is kept for as long as the contention lasts.
- R3: When both ports start matching in the same cycle from a state where neither held that address, the left port wins and r_busy_out is high.
- R4: A busy output drops in the same cycle that the addresses differ or either enable is removed.
- R5: A write from a port that is blocked (busy) leaves the memory unchanged, and it is not forwarded to the other port's read.
- R6: Lane i of a word is bits [9i+8:9i]. A write changes only the lanes whose lane write enable bit i is 1.
- R7: The read data of an enabled port updates at the next clock edge with the addressed word after that cycle's accepted writes from either port (write-first, opposite-port bypass). It holds while the port is disabled.
- R8: Address 2^ADDR_W-1 is the right mailbox. An unblocked left write there sets r_irq at the next edge. An unblocked right read there clears it. When set and clear coincide, set wins.
- R9: Address 2^ADDR_W-2 is the left mailbox. An unblocked right write there sets l_irq at the next edge, and an unblocked left read there clears it.
- R10: Reading the other port's mailbox leaves both interrupts unchanged.
- R11: A busy port neither sets the opposite interrupt by writing nor clears its own by reading its mailbox.
- R12: In slave mode (master_sel=0) both busy outputs stay low. A high busy input blocks that port's writes and mailbox clears, in the same way as internal busy.
- R13: During reset both read outputs, both interrupts and both busy outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 1 = master (busy driven), 0 = slave (busy taken from inputs) |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left write strobe (0 = read) |
| l_lane_we | input | LANES | Left per-lane write enables |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | LANES*LANE_W | Left write data |
| l_rdata | output | LANES*LANE_W | Left registered read data |
| l_busy_out | output | 1 | Left lost arbitration (master mode) |
| l_busy_in | input | 1 | Left busy from master (slave mode) |
| l_irq | output | 1 | Left interrupt (left mailbox written) |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right write strobe (0 = read) |
| r_lane_we | input | LANES | Right per-lane write enables |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | LANES*LANE_W | Right write data |
| r_rdata | output | LANES*LANE_W | Right registered read data |
| r_busy_out | output | 1 | Right lost arbitration (master mode) |
| r_busy_in | input | 1 | Right busy from master (slave mode) |
| r_irq | output | 1 | Right interrupt (right mailbox written) |

## Verification
The busy outputs are combinational: they follow the inputs within the same cycle. Read data and both interrupts are registered, so they become due at the first rising edge after the cycle that caused them. The bench drives every input on the falling edge. It checks busy one nanosecond after driving, before the rising edge. It checks read data and interrupts at the next falling edge, so each sample falls in the half-cycle where the result is settled. Arrival order is set up by holding one port steady for an idle or leading cycle before the other port joins, which makes the winner predictable.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    typedef enum logic {
        OWN_LEFT  = 1'b0,
        OWN_RIGHT = 1'b1
    } owner_e;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_lose,
    output logic              r_lose
);
    import dpr_pkg::*;

    typedef struct packed {
        logic              l_en;
        logic [ADDR_W-1:0] l_addr;
        logic              r_en;
        logic [ADDR_W-1:0] r_addr;
        logic              cont;
        owner_e            owner;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    match, l_held, r_held;
    owner_e  winner;

    always_comb begin
        st_d   = st_q;
        match  = l_en && r_en && (l_addr == r_addr);
        l_held = st_q.l_en && (st_q.l_addr == l_addr);
        r_held = st_q.r_en && (st_q.r_addr == r_addr);
        if (!match)
            winner = OWN_LEFT;
        else if (st_q.cont)
            winner = st_q.owner;       // keep ownership while contention lasts
        else if (r_held && !l_held)
            winner = OWN_RIGHT;        // right was there first
        else
            winner = OWN_LEFT;         // left first, or a tie
        st_d.l_en   = l_en;
        st_d.l_addr = l_addr;
        st_d.r_en   = r_en;
        st_d.r_addr = r_addr;
        st_d.cont   = match;
        st_d.owner  = winner;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign l_lose = match && (winner == OWN_RIGHT);
    assign r_lose = match && (winner == OWN_LEFT);
endmodule

// File: rtl/dpr_mailbox.sv
module dpr_mailbox #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_we,
    input  logic              l_blk,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic              r_we,
    input  logic              r_blk,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_irq,
    output logic              r_irq
);
    localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] L_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic l_irq;
        logic r_irq;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    set_r, clr_r, set_l, clr_l;

    always_comb begin
        st_d  = st_q;
        set_r = l_en &&  l_we && !l_blk && (l_addr == R_BOX);
        clr_r = r_en && !r_we && !r_blk && (r_addr == R_BOX);
        set_l = r_en &&  r_we && !r_blk && (r_addr == L_BOX);
        clr_l = l_en && !l_we && !l_blk && (l_addr == L_BOX);
        if (set_r)      st_d.r_irq = 1'b1;
        else if (clr_r) st_d.r_irq = 1'b0;
        if (set_l)      st_d.l_irq = 1'b1;
        else if (clr_l) st_d.l_irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign l_irq = st_q.l_irq;
    assign r_irq = st_q.r_irq;
endmodule

// File: rtl/dpr_storage.sv
module dpr_storage #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    l_en,
    input  logic                    l_wr,
    input  logic [LANES-1:0]        l_lane_we,
    input  logic [ADDR_W-1:0]       l_addr,
    input  logic [LANES*LANE_W-1:0] l_wdata,
    output logic [LANES*LANE_W-1:0] l_rdata,
    input  logic                    r_en,
    input  logic                    r_wr,
    input  logic [LANES-1:0]        r_lane_we,
    input  logic [ADDR_W-1:0]       r_addr,
    input  logic [LANES*LANE_W-1:0] r_wdata,
    output logic [LANES*LANE_W-1:0] r_rdata
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] l_rdata;
        logic [DATA_W-1:0] r_rdata;
    } rd_st_t;

    logic [DATA_W-1:0] mem [DEPTH];
    rd_st_t            st_d, st_q;
    logic [DATA_W-1:0] l_word, r_word;
    logic              same;

    function automatic logic [DATA_W-1:0] lane_put(
        input logic [DATA_W-1:0] base,
        input logic              hit,
        input logic [LANES-1:0]  lanes,
        input logic [DATA_W-1:0] data
    );
        logic [DATA_W-1:0] res;
        res = base;
        for (int i = 0; i < LANES; i++) begin
            if (hit && lanes[i]) res[i*LANE_W +: LANE_W] = data[i*LANE_W +: LANE_W];
        end
        return res;
    endfunction

    always_comb begin
        st_d   = st_q;
        same   = (l_addr == r_addr);
        // word after this cycle's writes: left lanes first, then right lanes
        l_word = lane_put(lane_put(mem[l_addr], l_wr, l_lane_we, l_wdata),
                          r_wr && same, r_lane_we, r_wdata);
        r_word = lane_put(lane_put(mem[r_addr], l_wr && same, l_lane_we, l_wdata),
                          r_wr, r_lane_we, r_wdata);
        if (l_en) st_d.l_rdata = l_word;
        if (r_en) st_d.r_rdata = r_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (l_wr) mem[l_addr] <= l_word;
        if (r_wr) mem[r_addr] <= r_word;
    end

    assign l_rdata = st_q.l_rdata;
    assign r_rdata = st_q.r_rdata;
endmodule

// File: rtl/dual_port_mailbox_ram.sv
module dual_port_mailbox_ram #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    master_sel,
    input  logic                    l_en,
    input  logic                    l_we,
    input  logic [LANES-1:0]        l_lane_we,
    input  logic [ADDR_W-1:0]       l_addr,
    input  logic [LANES*LANE_W-1:0] l_wdata,
    output logic [LANES*LANE_W-1:0] l_rdata,
    output logic                    l_busy_out,
    input  logic                    l_busy_in,
    output logic                    l_irq,
    input  logic                    r_en,
    input  logic                    r_we,
    input  logic [LANES-1:0]        r_lane_we,
    input  logic [ADDR_W-1:0]       r_addr,
    input  logic [LANES*LANE_W-1:0] r_wdata,
    output logic [LANES*LANE_W-1:0] r_rdata,
    output logic                    r_busy_out,
    input  logic                    r_busy_in,
    output logic                    r_irq
);
    logic l_lose, r_lose;
    logic l_blk, r_blk;
    logic l_wr, r_wr;

    dpr_arbiter #(.ADDR_W(ADDR_W)) i_arbiter (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_en   (l_en),
        .l_addr (l_addr),
        .r_en   (r_en),
        .r_addr (r_addr),
        .l_lose (l_lose),
        .r_lose (r_lose)
    );

    always_comb begin
        l_blk      = master_sel ? l_lose : l_busy_in;
        r_blk      = master_sel ? r_lose : r_busy_in;
        l_busy_out = master_sel && l_lose;
        r_busy_out = master_sel && r_lose;
        l_wr       = l_en && l_we && !l_blk;
        r_wr       = r_en && r_we && !r_blk;
    end

    dpr_storage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_storage (
        .clk       (clk),
        .rst_n     (rst_n),
        .l_en      (l_en),
        .l_wr      (l_wr),
        .l_lane_we (l_lane_we),
        .l_addr    (l_addr),
        .l_wdata   (l_wdata),
        .l_rdata   (l_rdata),
        .r_en      (r_en),
        .r_wr      (r_wr),
        .r_lane_we (r_lane_we),
        .r_addr    (r_addr),
        .r_wdata   (r_wdata),
        .r_rdata   (r_rdata)
    );

    dpr_mailbox #(.ADDR_W(ADDR_W)) i_mailbox (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_en   (l_en),
        .l_we   (l_we),
        .l_blk  (l_blk),
        .l_addr (l_addr),
        .r_en   (r_en),
        .r_we   (r_we),
        .r_blk  (r_blk),
        .r_addr (r_addr),
        .l_irq  (l_irq),
        .r_irq  (r_irq)
    );
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_sel,
    input logic              l_en,
    input logic              l_we,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_busy_out,
    input logic              l_busy_in,
    input logic              l_irq,
    input logic              r_en,
    input logic              r_we,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy_out,
    input logic              r_busy_in,
    input logic              r_irq
);
    localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] L_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic seen_q;
    logic same_word, lblk, rblk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assign same_word = l_en && r_en && (l_addr == r_addr);
    assign lblk      = master_sel ? l_busy_out : l_busy_in;
    assign rblk      = master_sel ? r_busy_out : r_busy_in;

    a_r1_busy_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy_out || r_busy_out) |-> same_word);

    a_r1_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && same_word) |-> (l_busy_out ^ r_busy_out));

    a_r2_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && master_sel && same_word && $past(same_word) && $past(r_busy_out))
        |-> r_busy_out);

    a_r3_tie_left: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && master_sel && same_word && !$past(l_en) && !$past(r_en))
        |-> r_busy_out);

    a_r8_right_set: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && l_we && !lblk && (l_addr == R_BOX)) |=> r_irq);

    a_r8_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (r_en && !r_we && !rblk && (r_addr == R_BOX) &&
         !(l_en && l_we && !lblk && (l_addr == R_BOX))) |=> !r_irq);

    a_r9_left_set: assert property (@(posedge clk) disable iff (!rst_n)
        (r_en && r_we && !rblk && (r_addr == L_BOX)) |=> l_irq);

    a_r12_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |-> (!l_busy_out && !r_busy_out));
endmodule

bind dual_port_mailbox_ram dpr_checker #(.ADDR_W(ADDR_W)) i_dpr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_sel (master_sel),
    .l_en       (l_en),
    .l_we       (l_we),
    .l_addr     (l_addr),
    .l_busy_out (l_busy_out),
    .l_busy_in  (l_busy_in),
    .l_irq      (l_irq),
    .r_en       (r_en),
    .r_we       (r_we),
    .r_addr     (r_addr),
    .r_busy_out (r_busy_out),
    .r_busy_in  (r_busy_in),
    .r_irq      (r_irq)
);

// File: tb/test_dual_port_mailbox_ram.sv
`timescale 1ns/1ps
module test_dual_port_mailbox_ram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_sel = 1'b1;
    logic        l_en = 0, l_we = 0, l_busy_in = 0;
    logic [3:0]  l_lane_we = '0;
    logic [7:0]  l_addr = '0;
    logic [35:0] l_wdata = '0;
    logic [35:0] l_rdata;
    logic        l_busy_out, l_irq;
    logic        r_en = 0, r_we = 0, r_busy_in = 0;
    logic [3:0]  r_lane_we = '0;
    logic [7:0]  r_addr = '0;
    logic [35:0] r_wdata = '0;
    logic [35:0] r_rdata;
    logic        r_busy_out, r_irq;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] R_BOX = 8'hFF;
    localparam logic [7:0] L_BOX = 8'hFE;

    always #2 clk = ~clk;

    dual_port_mailbox_ram i_dual_port_mailbox_ram (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
        .l_en(l_en), .l_we(l_we), .l_lane_we(l_lane_we), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_busy_out(l_busy_out),
        .l_busy_in(l_busy_in), .l_irq(l_irq),
        .r_en(r_en), .r_we(r_we), .r_lane_we(r_lane_we), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_busy_out(r_busy_out),
        .r_busy_in(r_busy_in), .r_irq(r_irq)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        l_en = 0; l_we = 0; l_lane_we = '0;
        r_en = 0; r_we = 0; r_lane_we = '0;
    endtask

    task automatic drive_l(input logic we, input logic [7:0] a, input logic [35:0] d, input logic [3:0] ln);
        l_en = 1; l_we = we; l_addr = a; l_wdata = d; l_lane_we = ln;
    endtask

    task automatic drive_r(input logic we, input logic [7:0] a, input logic [35:0] d, input logic [3:0] ln);
        r_en = 1; r_we = we; r_addr = a; r_wdata = d; r_lane_we = ln;
    endtask

    task automatic wr_l(input logic [7:0] a, input logic [35:0] d, input logic [3:0] ln);
        drive_l(1, a, d, ln); tick(); idle(); tick();
    endtask

    task automatic wr_r(input logic [7:0] a, input logic [35:0] d, input logic [3:0] ln);
        drive_r(1, a, d, ln); tick(); idle(); tick();
    endtask

    task automatic rd_l(input logic [7:0] a);
        drive_l(0, a, '0, '0); tick(); idle();
    endtask

    task automatic rd_r(input logic [7:0] a);
        drive_r(0, a, '0, '0); tick(); idle();
    endtask

    task automatic t_reset();
        repeat (3) tick();
        check("R13 l_rdata", l_rdata, 36'h0);
        check("R13 r_rdata", r_rdata, 36'h0);
        check("R13 l_irq", l_irq, 0);
        check("R13 r_irq", r_irq, 0);
        check("R13 busy", {l_busy_out, r_busy_out}, 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_lanes();
        logic [35:0] exp;
        wr_l(8'd10, 36'h1_2345_6789, 4'hF);
        rd_r(8'd10);
        check("R7 read back", r_rdata, 36'h1_2345_6789);
        wr_l(8'd10, 36'hF_FFFF_FFFF, 4'b0010);
        exp = (36'h1_2345_6789 & ~(36'h1FF << 9)) | (36'h1FF << 9);
        wr_r(8'd10, 36'h0, 4'b1000);
        exp = exp & ~(36'h1FF << 27);
        rd_l(8'd10);
        check("R6 lane merge", l_rdata, exp);
        tick();
        check("R7 hold when disabled", l_rdata, exp);
    endtask

    task automatic t_bypass();
        wr_l(8'd20, 36'h0_0000_000A, 4'hF);
        drive_l(1, 8'd20, 36'h5_5555_5555, 4'hF);
        drive_r(0, 8'd20, '0, '0);
        #1;
        check("R3 tie right busy", r_busy_out, 1);
        check("R3 tie left free", l_busy_out, 0);
        tick(); idle();
        check("R7 bypass to reader", r_rdata, 36'h5_5555_5555);
        tick();
    endtask

    task automatic t_left_first();
        wr_l(8'd30, 36'h0_0000_0030, 4'hF);
        drive_l(0, 8'd30, '0, '0);
        tick();
        drive_r(1, 8'd30, 36'h0_0000_000B, 4'hF);
        #1;
        check("R2 left first: right busy", r_busy_out, 1);
        check("R2 left first: left free", l_busy_out, 0);
        tick();
        check("R5 blocked write not seen", l_rdata, 36'h0_0000_0030);
        #1;
        check("R2 ownership kept", r_busy_out, 1);
        tick();
        l_addr = 8'd31; r_we = 0;
        #1;
        check("R4 address moved", r_busy_out, 0);
        tick(); idle(); tick();
        rd_r(8'd30);
        check("R5 memory unchanged", r_rdata, 36'h0_0000_0030);
        tick();
    endtask

    task automatic t_right_first();
        wr_l(8'd40, 36'h0_0000_0040, 4'hF);
        drive_r(0, 8'd40, '0, '0);
        tick();
        drive_l(1, 8'd40, 36'h0_0000_000C, 4'hF);
        #1;
        check("R2 right first: left busy", l_busy_out, 1);
        check("R2 right first: right free", r_busy_out, 0);
        tick();
        check("R5 no bypass of blocked write", r_rdata, 36'h0_0000_0040);
        r_en = 0;
        #1;
        check("R4 enable removed", l_busy_out, 0);
        tick(); idle(); tick();
        rd_r(8'd40);
        check("R4 write lands once free", r_rdata, 36'h0_0000_000C);
        tick();
    endtask

    task automatic t_tie();
        wr_l(8'd50, 36'h0_0000_0050, 4'hF);
        drive_l(0, 8'd50, '0, '0);
        drive_r(1, 8'd50, 36'h0_0000_000D, 4'hF);
        #1;
        check("R3 simultaneous: right busy", r_busy_out, 1);
        tick();
        check("R3 loser write dropped", l_rdata, 36'h0_0000_0050);
        #1;
        check("R3 left keeps win", {l_busy_out, r_busy_out}, 2'b01);
        tick(); idle(); tick();
    endtask

    task automatic t_mail_right();
        wr_l(R_BOX, 36'h0_0000_0077, 4'hF);
        check("R8 right irq set", r_irq, 1);
        rd_l(R_BOX);
        check("R10 foreign read keeps irq", r_irq, 1);
        rd_r(R_BOX);
        check("R8 owner read clears", r_irq, 0);
        check("R8 message", r_rdata, 36'h0_0000_0077);
        check("R8 left irq untouched", l_irq, 0);
        tick();
    endtask

    task automatic t_mail_left();
        wr_r(L_BOX, 36'h0_0000_0066, 4'hF);
        check("R9 left irq set", l_irq, 1);
        rd_r(L_BOX);
        check("R10 foreign read keeps irq", l_irq, 1);
        rd_l(L_BOX);
        check("R9 owner read clears", l_irq, 0);
        check("R9 message", l_rdata, 36'h0_0000_0066);
        tick();
    endtask

    task automatic t_busy_mail();
        wr_l(R_BOX, 36'h0_0000_0011, 4'hF);
        drive_l(0, R_BOX, '0, '0);
        tick();
        drive_r(0, R_BOX, '0, '0);
        #1;
        check("R11 right busy on own box", r_busy_out, 1);
        tick(); idle();
        check("R11 busy read keeps irq", r_irq, 1);
        tick();
        rd_r(R_BOX);
        check("R8 cleanup clear", r_irq, 0);
        tick();
        drive_l(0, L_BOX, '0, '0);
        tick();
        drive_r(1, L_BOX, 36'h0_0000_0099, 4'hF);
        #1;
        check("R11 right busy on left box", r_busy_out, 1);
        tick(); idle();
        check("R11 busy write no irq", l_irq, 0);
        tick();
    endtask

    task automatic t_slave();
        master_sel = 1'b0;
        wr_l(8'd60, 36'h0_0000_0060, 4'hF);
        drive_l(0, 8'd70, '0, '0);
        drive_r(0, 8'd70, '0, '0);
        #1;
        check("R12 slave busy outputs low", {l_busy_out, r_busy_out}, 2'b00);
        tick(); idle();
        l_busy_in = 1;
        drive_l(1, 8'd60, 36'h0_0000_000E, 4'hF);
        drive_r(1, 8'd61, 36'h0_0000_0061, 4'hF);
        tick(); idle();
        drive_l(1, R_BOX, 36'h0_0000_0001, 4'hF);
        tick(); idle();
        check("R12 blocked mailbox write", r_irq, 0);
        l_busy_in = 0;
        tick();
        rd_l(8'd60);
        check("R12 busy input blocks write", l_rdata, 36'h0_0000_0060);
        rd_l(8'd61);
        check("R12 other port writes", l_rdata, 36'h0_0000_0061);
        master_sel = 1'b1;
        tick();
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_lanes();
        t_bypass();
        t_left_first();
        t_right_first();
        t_tie();
        t_mail_right();
        t_mail_left();
        t_busy_mail();
        t_slave();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule